// File: doc/BRIEF.md
# Four-Line Event Interrupt Merger

This block collects twelve single-cycle event pulses from an imaging subsystem (DMA channels, a lens-correction engine, a noise-filter engine, a hardware sequencer, a CPU hand-off point and the master-port bus-error logic). It folds them onto four independent interrupt lines. Every event pulse lands in a fixed, sparse bit position of a 20-bit status word. Each of the four lines keeps its own sticky copy of that word, its own enable mask and its own output mode. A line is raised when an event it has enabled is pending.

Software reaches the block through a plain synchronous register port. A write takes effect at the clock edge on which `reg_wr` is high. Reads are combinational from registered state. Each line has four word addresses: raw status, masked status, enable-set and enable-clear. One control word holds the four mode bits and a write-only strobe bit. The strobe emits a one-cycle processing-done pulse toward the sequencer. The port has no streams, so it carries no valid/ready handshake and never stalls.

Top module: `irqm_merge`

## Requirements
- R1: Event input `ev_i[k]` maps to status bit position 0,1,8,9,10,11,12,13,14,16,18,19 for k = 0..11 respectively. One pulse sets that bit in the raw status of all four lines at the next clock edge.
- R2: Raw status bits are sticky. They stay set with no further events until software clears them.
- R3: Writing to raw status address 4*n+0 clears the bits written as 1 for line n only. Bits written as 0 are unchanged. An event arriving in the same cycle as its bit's clear leaves the bit set.
- R4: Writing to enable-set address 4*n+2 enables the bits written as 1 for line n. Zeros have no effect.
- R5: Writing to enable-clear address 4*n+3 disables the bits written as 1 for line n. Zeros have no effect.
- R6: Masked status at address 4*n+1 reads raw status AND enable of line n. Writes to it have no effect.
- R7: Reading either enable address of line n returns that line's current enable mask.
- R8: Status and enable bits at positions 2-7, 15 and 17 always read 0 and ignore writes.
- R9: With mode bit n = 0, `irq_o[n]` is a level equal to the OR of line n's masked status.
- R10: With mode bit n = 1, `irq_o[n]` is high for exactly one cycle whenever any masked bit of line n goes from 0 to 1. This also happens when a pending bit becomes enabled.
- R11: Control address 16 holds the mode of line n in bit n. Writing 1 to its bit 8 produces a one-cycle `cpu_done_o` pulse in the cycle after the write. Bit 8 reads 0.
- R12: After reset every status, enable and mode bit is 0. All `irq_o` lines and `cpu_done_o` are low.
- R13: Clearing or masking on one line does not alter the status, enable or output of another line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_i | input | 12 | Single-cycle event pulses, mapped per R1 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 20 | Register write data |
| reg_rdata | output | 20 | Register read data (combinational) |
| irq_o | output | 4 | Interrupt lines, one per output |
| cpu_done_o | output | 1 | One-cycle processing-done pulse |

## Verification
The bench builds the block with its default parameters: four lines, a 20-bit status word and twelve events. This puts every mapped bit position and every unassigned gap within reach. All four lines run side by side, so cross-line isolation can be observed directly. Both the level mode and the pulse mode are used on different lines at the same time. Same-cycle collisions are driven on purpose: an event arriving with a raw-status clear, and enabling a bit that is already pending.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int NUM_OUT   = 4;
  localparam int NUM_EV    = 12;
  localparam int STAT_W    = 20;
  localparam int DATA_W    = STAT_W;
  localparam int OSEL_W    = $clog2(NUM_OUT);
  localparam int ADDR_W    = OSEL_W + 3;
  localparam int REGS_PER  = 4;
  localparam int CPU_DONE_BIT = 8;

  typedef enum logic [1:0] {
    SEL_RAW    = 2'd0,
    SEL_MASKED = 2'd1,
    SEL_ENSET  = 2'd2,
    SEL_ENCLR  = 2'd3
  } reg_sel_e;

  function automatic int ev_pos(input int k);
    case (k)
      0:  ev_pos = 0;
      1:  ev_pos = 1;
      2:  ev_pos = 8;
      3:  ev_pos = 9;
      4:  ev_pos = 10;
      5:  ev_pos = 11;
      6:  ev_pos = 12;
      7:  ev_pos = 13;
      8:  ev_pos = 14;
      9:  ev_pos = 16;
      10: ev_pos = 18;
      default: ev_pos = 19;
    endcase
  endfunction

  function automatic logic [STAT_W-1:0] valid_mask();
    logic [STAT_W-1:0] m;
    m = '0;
    for (int k = 0; k < NUM_EV; k++) m[ev_pos(k)] = 1'b1;
    return m;
  endfunction

  localparam logic [STAT_W-1:0] VALID_MASK = valid_mask();
endpackage

// File: rtl/irqm_chan.sv
module irqm_chan
  import irqm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] ev_bits,
  input  logic              clr_we,
  input  logic              set_we,
  input  logic              dis_we,
  input  logic [STAT_W-1:0] wdata,
  input  logic              mode,
  output logic [STAT_W-1:0] raw_o,
  output logic [STAT_W-1:0] en_o,
  output logic [STAT_W-1:0] masked_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] raw_q, en_q, prev_q, raw_d, en_d, masked, rise;

  always_comb begin
    raw_d = raw_q;
    if (clr_we) raw_d = raw_d & ~wdata;
    raw_d = (raw_d | ev_bits) & VALID_MASK;
    en_d = en_q;
    if (set_we) en_d = en_d | wdata;
    if (dis_we) en_d = en_d & ~wdata;
    en_d = en_d & VALID_MASK;
  end

  assign masked = raw_q & en_q;
  assign rise   = masked & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      en_q   <= '0;
      prev_q <= '0;
    end else begin
      raw_q  <= raw_d;
      en_q   <= en_d;
      prev_q <= masked;
    end
  end

  assign raw_o    = raw_q;
  assign en_o     = en_q;
  assign masked_o = masked;
  assign irq_o    = mode ? (|rise) : (|masked);

  // R1
  event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_bits) |=> ((raw_q & $past(ev_bits)) == $past(ev_bits)));
  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((raw_q & $past(raw_q)) == $past(raw_q)));
  // R4
  enset_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !dis_we) |=> ((en_q & $past(en_q)) == $past(en_q)));
  // R5
  enclr_no_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_we && !set_we) |=> ((en_q & ~$past(en_q)) == '0));
  // R8
  gap_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_o | en_o) & ~VALID_MASK) == '0);
  // R10
  pulse_needs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && $stable(masked_o)) |-> !irq_o);
endmodule

// File: rtl/irqm_regif.sv
module irqm_regif
  import irqm_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           reg_wr,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic [DATA_W-1:0]              reg_wdata,
  input  logic [NUM_OUT-1:0][STAT_W-1:0] raw_i,
  input  logic [NUM_OUT-1:0][STAT_W-1:0] en_i,
  input  logic [NUM_OUT-1:0][STAT_W-1:0] masked_i,
  output logic [NUM_OUT-1:0]             clr_we,
  output logic [NUM_OUT-1:0]             set_we,
  output logic [NUM_OUT-1:0]             dis_we,
  output logic [NUM_OUT-1:0]             mode_o,
  output logic                           cpu_done_o,
  output logic [DATA_W-1:0]              reg_rdata
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_OUT * REGS_PER);

  logic              in_chan, ctrl_hit;
  logic [OSEL_W-1:0] sel_out;
  reg_sel_e          sel_reg;
  logic [NUM_OUT-1:0] mode_q;
  logic               done_q;

  assign in_chan  = reg_addr < CTRL_ADDR;
  assign ctrl_hit = reg_addr == CTRL_ADDR;
  assign sel_out  = reg_addr[OSEL_W+1:2];
  assign sel_reg  = reg_sel_e'(reg_addr[1:0]);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_strobe
    logic hit;
    assign hit       = reg_wr && in_chan && (sel_out == OSEL_W'(i));
    assign clr_we[i] = hit && (sel_reg == SEL_RAW);
    assign set_we[i] = hit && (sel_reg == SEL_ENSET);
    assign dis_we[i] = hit && (sel_reg == SEL_ENCLR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (reg_wr && ctrl_hit) mode_q <= reg_wdata[NUM_OUT-1:0];
      done_q <= reg_wr && ctrl_hit && reg_wdata[CPU_DONE_BIT];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (in_chan) begin
      case (sel_reg)
        SEL_RAW:    reg_rdata = raw_i[sel_out];
        SEL_MASKED: reg_rdata = masked_i[sel_out];
        default:    reg_rdata = en_i[sel_out];
      endcase
    end else if (ctrl_hit) begin
      reg_rdata[NUM_OUT-1:0] = mode_q;
    end
  end

  assign mode_o     = mode_q;
  assign cpu_done_o = done_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && ctrl_hit && reg_wdata[CPU_DONE_BIT]) |=> cpu_done_o);
  // R11
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && ctrl_hit) |=> !cpu_done_o);
endmodule

// File: rtl/irqm_merge.sv
module irqm_merge
  import irqm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EV-1:0]  ev_i,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [NUM_OUT-1:0] irq_o,
  output logic               cpu_done_o
);
  logic [STAT_W-1:0]              ev_bits;
  logic [NUM_OUT-1:0][STAT_W-1:0] raw, en, masked;
  logic [NUM_OUT-1:0]             clr_we, set_we, dis_we, mode;

  always_comb begin
    ev_bits = '0;
    for (int k = 0; k < NUM_EV; k++) ev_bits[ev_pos(k)] = ev_i[k];
  end

  irqm_regif u_regif (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .raw_i(raw), .en_i(en), .masked_i(masked),
    .clr_we(clr_we), .set_we(set_we), .dis_we(dis_we), .mode_o(mode),
    .cpu_done_o(cpu_done_o), .reg_rdata(reg_rdata)
  );

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_chan
    irqm_chan u_chan (
      .clk(clk), .rst_n(rst_n), .ev_bits(ev_bits),
      .clr_we(clr_we[n]), .set_we(set_we[n]), .dis_we(dis_we[n]),
      .wdata(reg_wdata[STAT_W-1:0]), .mode(mode[n]),
      .raw_o(raw[n]), .en_o(en[n]), .masked_o(masked[n]), .irq_o(irq_o[n])
    );
  end

  // R13
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({clr_we, set_we, dis_we}) <= 1);
  // R12
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (irq_o == '0 && !cpu_done_o));
endmodule

// File: tb/irqm_merge_bench.sv
module irqm_merge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] ev_i = '0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [19:0] reg_wdata = '0;
  logic [19:0] reg_rdata;
  logic [3:0]  irq_o;
  logic        cpu_done_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [19:0] GOOD = 20'hD7F03;

  irqm_merge u_irqm_merge (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .cpu_done_o(cpu_done_o)
  );

  always #5 clk = ~clk;

  function automatic int pos_of(input int k);
    int t [12] = '{0, 1, 8, 9, 10, 11, 12, 13, 14, 16, 18, 19};
    return t[k];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [19:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'(addr); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [19:0] d);
    reg_addr = 5'(addr);
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [11:0] m);
    @(negedge clk);
    ev_i = m;
    @(negedge clk);
    ev_i = '0;
    #1;
  endtask

  task automatic clear_all();
    for (int n = 0; n < 4; n++) begin
      wr(4*n, 20'hFFFFF);
      wr(4*n+3, 20'hFFFFF);
    end
    wr(16, 20'h0);
  endtask

  task automatic t_reset();
    logic [19:0] d;
    #1;
    check(irq_o == 4'h0 && !cpu_done_o, "R12 outputs", {irq_o, cpu_done_o}, 0);
    for (int a = 0; a < 17; a++) begin
      rd(a, d);
      check(d == 20'h0, "R12 register", d, 0);
    end
  endtask

  task automatic t_map();
    logic [19:0] d;
    for (int k = 0; k < 12; k++) begin
      pulse(12'(1 << k));
      for (int n = 0; n < 4; n++) begin
        rd(4*n, d);
        check(d == 20'(1 << pos_of(k)), "R1 map", d, 1 << pos_of(k));
      end
      for (int n = 0; n < 4; n++) wr(4*n, 20'hFFFFF);
    end
  endtask

  task automatic t_sticky_clear();
    logic [19:0] d;
    pulse(12'b0000_0000_0011);
    repeat (5) @(negedge clk);
    rd(0, d);
    check(d == 20'h3, "R2 sticky", d, 3);
    wr(0, 20'h0);
    rd(0, d);
    check(d == 20'h3, "R3 zero write", d, 3);
    wr(0, 20'h2);
    rd(0, d);
    check(d == 20'h1, "R3 partial clear", d, 1);
    rd(4, d);
    check(d == 20'h3, "R13 other line raw", d, 3);
    @(negedge clk);
    ev_i = 12'h001; reg_wr = 1'b1; reg_addr = 5'd0; reg_wdata = 20'h1;
    @(negedge clk);
    ev_i = '0; reg_wr = 1'b0;
    rd(0, d);
    check(d == 20'h1, "R3 event wins", d, 1);
    clear_all();
  endtask

  task automatic t_enable();
    logic [19:0] d;
    wr(10, 20'hFFFFF);
    rd(10, d);
    check(d == GOOD, "R8 enable gaps", d, GOOD);
    rd(11, d);
    check(d == GOOD, "R7 read via clear addr", d, GOOD);
    wr(10, 20'h0);
    wr(11, 20'h0);
    rd(10, d);
    check(d == GOOD, "R4 R5 zero writes", d, GOOD);
    wr(11, 20'h00100);
    rd(11, d);
    check(d == (GOOD & ~20'h100), "R5 clear bit", d, GOOD & ~20'h100);
    rd(14, d);
    check(d == 20'h0, "R13 other line mask", d, 0);
    pulse(12'b0000_0000_0110);
    rd(9, d);
    check(d == 20'h002, "R6 masked", d, 2);
    wr(9, 20'hFFFFF);
    rd(8, d);
    check(d == 20'h102, "R6 masked write ignored", d, 20'h102);
    wr(8, 20'hFFFFF);
    rd(8, d);
    check(d == 20'h0, "R8 raw clear", d, 0);
    clear_all();
  endtask

  task automatic t_level();
    wr(15 - 1, 20'h04000);
    pulse(12'h100);
    check(irq_o == 4'b1000, "R9 level high", irq_o, 8);
    repeat (4) @(negedge clk);
    #1;
    check(irq_o == 4'b1000, "R9 level holds", irq_o, 8);
    wr(12, 20'h04000);
    #1;
    check(irq_o == 4'b0000, "R9 level drops", irq_o, 0);
    clear_all();
  endtask

  task automatic t_pulse();
    logic [19:0] d;
    wr(16, 20'h2);
    rd(16, d);
    check(d == 20'h2, "R11 mode readback", d, 2);
    wr(6, 20'h1);
    wr(2, 20'h1);
    pulse(12'h001);
    check(irq_o == 4'b0011, "R10 pulse and R9 level", irq_o, 3);
    @(negedge clk); #1;
    check(irq_o == 4'b0001, "R10 pulse one cycle", irq_o, 1);
    pulse(12'h002);
    check(irq_o[1] == 1'b0, "R10 masked event no pulse", irq_o, 1);
    wr(6, 20'h2);
    #1;
    check(irq_o[1] == 1'b1, "R10 enable pending bit", irq_o, 3);
    @(negedge clk); #1;
    check(irq_o[1] == 1'b0, "R10 pulse ends", irq_o, 1);
    clear_all();
  endtask

  task automatic t_cpu_done();
    logic [19:0] d;
    wr(16, 20'h105);
    #1;
    check(cpu_done_o == 1'b1, "R11 done pulse", cpu_done_o, 1);
    rd(16, d);
    check(d == 20'h005, "R11 strobe reads zero", d, 5);
    @(negedge clk); #1;
    check(cpu_done_o == 1'b0, "R11 done one cycle", cpu_done_o, 0);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_sticky_clear();
    t_enable();
    t_level();
    t_pulse();
    t_cpu_done();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule